// File: doc/BRIEF.md
# Effective Address Generator

This block turns an instruction word into the addresses that a 16-bit, word-addressed machine needs. The address space is 2^16 words. The block handles seven address forms:

- PC-relative addressing.
- Register base plus a short offset.
- Two-step pointer-through-memory addressing.
- The load-effective-address result.
- Conditional branch targets.
- Register-held jump targets.
- Service-vector jumps.

It produces three results: the memory address for the data access, the next program counter value, and the value that a load-effective-address instruction writes back.

A pulse on `start` hands the block the instruction word and three values for that instruction: the already incremented PC, the contents of the base register named by instruction bits 8:6, and the condition flags. Most forms finish one cycle later. The pointer and service-vector forms need one extra memory read. The block issues that read itself, keeps `busy` high while it waits, and then raises `done` for one cycle. The results stay on the outputs until the next accepted `start`.

Top module: `ea_unit`

## Requirements
- R1: While reset is held and right after it, `busy`, `done` and `mem_rd` are low, and `mar`, `next_pc` and `lea_val` are zero.
- R2: For opcodes 0x2 and 0x3 (instruction bits 15:12), `done` rises one cycle after an accepted `start`. `mar` then equals `pc_inc` plus the sign-extended bits 8:0, and `next_pc` equals `pc_inc`. No memory read is issued.
- R3: For opcodes 0x6 and 0x7, `mar` equals `base_val` plus the sign-extended bits 5:0, and `done` arrives one cycle after `start`.
- R4: For opcodes 0xA and 0xB, the cycle after `start` has `mem_rd` high with `mar` set to the PC-relative sum. The next cycle keeps `busy` high. The cycle after that has `done` high, with `mar` equal to the word that memory returned for the first address. `mem_rd` is high for exactly one cycle, and `busy` and `done` are never high together.
- R5: For opcode 0xE, `lea_val` equals `pc_inc` plus the sign-extended bits 8:0, `next_pc` equals `pc_inc`, and no memory read is issued.
- R6: For opcode 0x0, `mar` shows the PC-relative sum. `next_pc` is that sum when (bits 11:9 AND `cc_nzp`) is nonzero, and `pc_inc` otherwise. Bit 11 pairs with `cc_nzp[2]` (negative), bit 10 with `cc_nzp[1]` (zero), and bit 9 with `cc_nzp[0]` (positive).
- R7: For opcode 0xC, `next_pc` and `mar` equal `base_val`, with no offset added.
- R8: For opcode 0xF, `mar` is bits 7:0 zero-extended during a one-cycle read. `next_pc` becomes the word returned for that address, and `done` rises three cycles after `start`.
- R9: Any other opcode finishes one cycle after `start`, with `mar` and `next_pc` equal to `pc_inc`.
- R10: A `start` that arrives while `busy` or `done` is high is ignored. The results and the timing of the operation in progress do not change.
- R11: While idle and without `start`, `mar`, `next_pc` and `lea_val` hold their last values, whatever the other inputs do.
- R12: Every address sum wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin evaluating `instr` (taken only when idle) |
| instr | input | 16 | Instruction word |
| pc_inc | input | AW | Program counter after increment |
| base_val | input | AW | Contents of the register selected by instr[8:6] |
| cc_nzp | input | 3 | Condition flags: negative, zero, positive |
| mem_rdata | input | AW | Read data, valid the cycle after `mem_rd` |
| mem_rd | output | 1 | Memory read request at address `mar` |
| mar | output | AW | Memory address |
| next_pc | output | AW | Selected next program counter |
| lea_val | output | AW | Address value for register write-back |
| busy | output | 1 | Extra memory read in progress |
| done | output | 1 | Results valid, one-cycle pulse |

## Verification
The bench builds the block with its default values: 16-bit addresses, a 9-bit long offset, a 6-bit short offset, an 8-bit vector field and the carry-select adder variant. At this width, a PC of 0xFFFF with a positive offset and a small base with a negative offset both reach the wrap-around of R12. The split adder's carry from the low half into the high half is also exercised. The bench memory returns a word computed from the address, so the values fetched by the pointer and vector forms are known in advance for every address.

// File: rtl/ea_pkg.sv
package ea_pkg;

   localparam int unsigned IW = 16;

   localparam logic [3:0] OPC_BR   = 4'h0;
   localparam logic [3:0] OPC_LD   = 4'h2;
   localparam logic [3:0] OPC_ST   = 4'h3;
   localparam logic [3:0] OPC_LDR  = 4'h6;
   localparam logic [3:0] OPC_STR  = 4'h7;
   localparam logic [3:0] OPC_LDI  = 4'hA;
   localparam logic [3:0] OPC_STI  = 4'hB;
   localparam logic [3:0] OPC_JMP  = 4'hC;
   localparam logic [3:0] OPC_LEA  = 4'hE;
   localparam logic [3:0] OPC_TRAP = 4'hF;

   typedef enum logic [2:0] {
      K_PCREL, K_BASEOFS, K_POINTER, K_EFFADDR,
      K_BRANCH, K_REGJUMP, K_VECTOR, K_PLAIN
   } ea_kind_e;

   typedef enum logic [1:0] { OFS_ZERO, OFS_SHORT, OFS_LONG } ea_ofs_e;

   typedef enum logic { SRC_PC, SRC_REG } ea_src_e;

   typedef struct packed {
      ea_kind_e kind;
      ea_src_e  src;
      ea_ofs_e  ofs;
      logic     two_phase;
   } ea_ctl_t;

   typedef enum logic [1:0] { ST_IDLE, ST_PTR, ST_CAPT, ST_DONE } ea_state_e;

endpackage

// File: rtl/ea_decode.sv
module ea_decode
   import ea_pkg::*;
(
   input  logic [3:0] opcode,
   input  logic [2:0] cond_mask,
   input  logic [2:0] cc_nzp,
   output ea_ctl_t    ctl,
   output logic       br_taken
);

   always_comb begin
      ctl = '{kind: K_PLAIN, src: SRC_PC, ofs: OFS_ZERO, two_phase: 1'b0};
      unique case (opcode)
         OPC_LD, OPC_ST:   ctl = '{kind: K_PCREL,   src: SRC_PC,  ofs: OFS_LONG,  two_phase: 1'b0};
         OPC_LDR, OPC_STR: ctl = '{kind: K_BASEOFS, src: SRC_REG, ofs: OFS_SHORT, two_phase: 1'b0};
         OPC_LDI, OPC_STI: ctl = '{kind: K_POINTER, src: SRC_PC,  ofs: OFS_LONG,  two_phase: 1'b1};
         OPC_LEA:          ctl = '{kind: K_EFFADDR, src: SRC_PC,  ofs: OFS_LONG,  two_phase: 1'b0};
         OPC_BR:           ctl = '{kind: K_BRANCH,  src: SRC_PC,  ofs: OFS_LONG,  two_phase: 1'b0};
         OPC_JMP:          ctl = '{kind: K_REGJUMP, src: SRC_REG, ofs: OFS_ZERO,  two_phase: 1'b0};
         OPC_TRAP:         ctl = '{kind: K_VECTOR,  src: SRC_PC,  ofs: OFS_ZERO,  two_phase: 1'b1};
         default:          ctl = '{kind: K_PLAIN,   src: SRC_PC,  ofs: OFS_ZERO,  two_phase: 1'b0};
      endcase
   end

   // branch condition: any requested flag that is currently set
   assign br_taken = |(cond_mask & cc_nzp);

endmodule

// File: rtl/ea_adder.sv
module ea_adder
   import ea_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned LONG_W    = 9,
   parameter int unsigned SHORT_W   = 6,
   parameter bit          SPLIT_ADD = 1'b1
)(
   input  logic [AW-1:0]     pc_inc,
   input  logic [AW-1:0]     base_val,
   input  logic [LONG_W-1:0] ofs_field,
   input  ea_src_e           src,
   input  ea_ofs_e           ofs_sel,
   output logic [AW-1:0]     sum
);

   localparam int unsigned LPAD = AW - LONG_W;
   localparam int unsigned SPAD = AW - SHORT_W;
   localparam int unsigned HLO  = AW / 2;
   localparam int unsigned HHI  = AW - HLO;

   logic [AW-1:0] ext_long, ext_short, opa, opb;

   assign ext_long  = {{LPAD{ofs_field[LONG_W-1]}},  ofs_field};
   assign ext_short = {{SPAD{ofs_field[SHORT_W-1]}}, ofs_field[SHORT_W-1:0]};
   assign opa       = (src == SRC_REG) ? base_val : pc_inc;

   always_comb begin
      unique case (ofs_sel)
         OFS_LONG:  opb = ext_long;
         OFS_SHORT: opb = ext_short;
         default:   opb = '0;
      endcase
   end

   generate
      if (SPLIT_ADD) begin : g_csel
         logic [HLO:0]   lo;
         logic [HHI-1:0] hi0, hi1;
         assign lo  = {1'b0, opa[HLO-1:0]} + {1'b0, opb[HLO-1:0]};
         assign hi0 = opa[AW-1:HLO] + opb[AW-1:HLO];
         assign hi1 = hi0 + {{(HHI-1){1'b0}}, 1'b1};
         assign sum = {lo[HLO] ? hi1 : hi0, lo[HLO-1:0]};
      end else begin : g_ripple
         assign sum = opa + opb;
      end
   endgenerate

endmodule

// File: rtl/ea_seq.sv
module ea_seq
   import ea_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic two_phase,
   output logic accept,
   output logic capture,
   output logic busy,
   output logic done,
   output logic mem_rd
);

   ea_state_e state_q, state_d;

   assign accept = (state_q == ST_IDLE) && start;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start) state_d = two_phase ? ST_PTR : ST_DONE;
         ST_PTR:  state_d = ST_CAPT;
         ST_CAPT: state_d = ST_DONE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign capture = (state_q == ST_CAPT);
   assign mem_rd  = (state_q == ST_PTR);
   assign busy    = (state_q == ST_PTR) || (state_q == ST_CAPT);
   assign done    = (state_q == ST_DONE);

endmodule

// File: rtl/ea_unit.sv
module ea_unit
   import ea_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned LONG_W    = 9,
   parameter int unsigned SHORT_W   = 6,
   parameter int unsigned VEC_W     = 8,
   parameter bit          SPLIT_ADD = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [15:0]   instr,
   input  logic [AW-1:0] pc_inc,
   input  logic [AW-1:0] base_val,
   input  logic [2:0]    cc_nzp,
   input  logic [AW-1:0] mem_rdata,
   output logic          mem_rd,
   output logic [AW-1:0] mar,
   output logic [AW-1:0] next_pc,
   output logic [AW-1:0] lea_val,
   output logic          busy,
   output logic          done
);

   localparam int unsigned VPAD = AW - VEC_W;

   generate
      if (AW < IW)           begin : g_bad_aw  $error("AW below instruction width"); end
      if (LONG_W != 9)       begin : g_bad_lw  $error("long offset must span bits 8:0"); end
      if (SHORT_W != 6)      begin : g_bad_sw  $error("short offset must span bits 5:0"); end
      if (VEC_W != 8)        begin : g_bad_vw  $error("vector must span bits 7:0"); end
      if (AW % 2 != 0)       begin : g_bad_odd $error("AW must be even"); end
   endgenerate

   ea_ctl_t       ctl;
   logic          br_taken, accept, capture;
   logic [AW-1:0] sum, vec_addr;
   ea_kind_e      kind_q;
   logic [AW-1:0] mar_q, npc_q, lea_q;
   logic          unused_regsel;

   assign unused_regsel = ^instr[8:6];

   ea_decode u_dec (
      .opcode   (instr[15:12]),
      .cond_mask(instr[11:9]),
      .cc_nzp   (cc_nzp),
      .ctl      (ctl),
      .br_taken (br_taken)
   );

   ea_adder #(
      .AW(AW), .LONG_W(LONG_W), .SHORT_W(SHORT_W), .SPLIT_ADD(SPLIT_ADD)
   ) u_add (
      .pc_inc   (pc_inc),
      .base_val (base_val),
      .ofs_field(instr[LONG_W-1:0]),
      .src      (ctl.src),
      .ofs_sel  (ctl.ofs),
      .sum      (sum)
   );

   ea_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .two_phase(ctl.two_phase),
      .accept   (accept),
      .capture  (capture),
      .busy     (busy),
      .done     (done),
      .mem_rd   (mem_rd)
   );

   assign vec_addr = {{VPAD{1'b0}}, instr[VEC_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= K_PLAIN;
         mar_q  <= '0;
         npc_q  <= '0;
         lea_q  <= '0;
      end else if (accept) begin
         kind_q <= ctl.kind;
         mar_q  <= (ctl.kind == K_VECTOR) ? vec_addr : sum;
         lea_q  <= sum;
         unique case (ctl.kind)
            K_BRANCH:  npc_q <= br_taken ? sum : pc_inc;
            K_REGJUMP: npc_q <= sum;
            default:   npc_q <= pc_inc;
         endcase
      end else if (capture) begin
         if (kind_q == K_VECTOR) npc_q <= mem_rdata;
         else                    mar_q <= mem_rdata;
      end
   end

   assign mar     = mar_q;
   assign next_pc = npc_q;
   assign lea_val = lea_q;

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
   parameter int unsigned AW = 16
)(
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          mem_rd,
   input logic          busy,
   input logic          done,
   input logic [AW-1:0] mar,
   input logic [AW-1:0] next_pc,
   input logic [AW-1:0] lea_val
);

   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd); // R4

   AST_RD_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> busy); // R4

   AST_BUSY_DONE_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done)); // R4

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy); // R10

   AST_RD_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> busy); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !done && !start) |=> ($stable(mar) && $stable(next_pc) && $stable(lea_val))); // R11

   AST_START_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !done) |=> (busy || done)); // R9

endmodule

bind ea_unit ea_unit_chk #(.AW(AW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .mem_rd (mem_rd),
   .busy   (busy),
   .done   (done),
   .mar    (mar),
   .next_pc(next_pc),
   .lea_val(lea_val)
);

// File: tb/ea_unit_bench.sv
module ea_unit_bench;

   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr = '0, pc_inc = '0, base_val = '0, mem_rdata = '0;
   logic [2:0]  cc_nzp = '0;
   logic        mem_rd, busy, done;
   logic [15:0] mar, next_pc, lea_val;

   int    n_vec = 0, n_bad = 0, cycles = 0;
   bit    armed = 1'b0;
   string cur_tag = "R1";

   // reference model state
   int          m_ph = 0;
   logic [15:0] m_mar = '0, m_npc = '0, m_lea = '0;
   bit          m_vec = 1'b0, m_is_lea = 1'b0;
   string       m_tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   ea_unit u_ea_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .pc_inc(pc_inc), .base_val(base_val), .cc_nzp(cc_nzp),
      .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mar(mar),
      .next_pc(next_pc), .lea_val(lea_val), .busy(busy), .done(done)
   );

   function automatic logic [15:0] mem_word(input logic [15:0] a);
      return {a[7:0], a[15:8]} ^ 16'hC3A5;
   endfunction

   // synchronous memory model
   always @(posedge clk) if (mem_rd) mem_rdata <= mem_word(mar);

   // behavioural reference, one step per clock
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_mar = '0; m_npc = '0; m_lea = '0; m_tag = "R1";
      end else begin
         case (m_ph)
            0: if (start) begin
               logic [15:0] s9, s6, rel;
               int op;
               op  = int'(instr[15:12]);
               s9  = {{7{instr[8]}}, instr[8:0]};
               s6  = {{10{instr[5]}}, instr[5:0]};
               rel = pc_inc + s9;
               m_vec = (op == 15); m_is_lea = (op == 14);
               m_lea = rel; m_npc = pc_inc; m_mar = pc_inc;
               m_tag = cur_tag;
               if (op == 2 || op == 3 || op == 10 || op == 11 || op == 14) m_mar = rel;
               if (op == 6 || op == 7) m_mar = base_val + s6;
               if (op == 0) begin
                  m_mar = rel;
                  if ((instr[11:9] & cc_nzp) != 3'b000) m_npc = rel;
               end
               if (op == 12) begin m_mar = base_val; m_npc = base_val; end
               if (op == 15) m_mar = {8'h00, instr[7:0]};
               m_ph = (op == 10 || op == 11 || op == 15) ? 1 : 3;
            end
            1: begin if (start) m_tag = "R10"; m_ph = 2; end
            2: begin
               if (start) m_tag = "R10";
               if (m_vec) m_npc = mem_word(m_mar);
               else       m_mar = mem_word(m_mar);
               m_ph = 3;
            end
            default: begin if (start) m_tag = "R10"; m_ph = 0; end
         endcase
         if (m_ph == 0 && m_tag != "R10") m_tag = "R11";
      end
   end

   task automatic miss(input string what, input logic [15:0] act, input logic [15:0] exp);
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", m_tag, what, act, exp);
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (armed) begin
         n_vec++;
         if (busy   !== (m_ph == 1 || m_ph == 2)) miss("busy",   {15'b0, busy},   {15'b0, 1'(m_ph == 1 || m_ph == 2)});
         if (done   !== (m_ph == 3))              miss("done",   {15'b0, done},   {15'b0, 1'(m_ph == 3)});
         if (mem_rd !== (m_ph == 1))              miss("mem_rd", {15'b0, mem_rd}, {15'b0, 1'(m_ph == 1)});
         if (mar !== m_mar) miss("mar", mar, m_mar);
         if ((m_ph == 3 || m_tag == "R1") && next_pc !== m_npc) miss("next_pc", next_pc, m_npc);
         if (((m_ph == 3 && m_is_lea) || m_tag == "R1") && lea_val !== m_lea) miss("lea_val", lea_val, m_lea);
      end
   end

   function automatic logic [15:0] mk9(input logic [3:0] op, input logic [2:0] r, input logic [8:0] o);
      return {op, r, o};
   endfunction
   function automatic logic [15:0] mk6(input logic [3:0] op, input logic [2:0] b, input logic [5:0] o);
      return {op, 3'b011, b, o};
   endfunction

   task automatic run_op(input logic [15:0] ins, input logic [15:0] pc, input logic [15:0] bv,
                         input logic [2:0] cc, input string tag, input logic [15:0] poke);
      @(negedge clk);
      instr = ins; pc_inc = pc; base_val = bv; cc_nzp = cc; cur_tag = tag; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke != 16'h0000) begin
         instr = poke; pc_inc = ~pc; base_val = ~bv; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (m_ph != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      armed = 1'b1;                       // R1: reset values checked here
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_op(mk9(4'h2, 3'd1, 9'h0FF), 16'h3000, 16'h0, 3'b000, "R2", 16'h0);
      run_op(mk9(4'h3, 3'd2, 9'h1FB), 16'h3005, 16'h0, 3'b000, "R2", 16'h0);
      run_op(mk9(4'h2, 3'd0, 9'h001), 16'hFFFF, 16'h0, 3'b000, "R12", 16'h0);
      run_op(mk6(4'h6, 3'd1, 6'd14), 16'h3001, 16'h3100, 3'b000, "R3", 16'h0);
      run_op(mk6(4'h7, 3'd2, 6'h38), 16'h3001, 16'h0005, 3'b000, "R12", 16'h0);
      run_op(mk6(4'h6, 3'd3, 6'h20), 16'h0000, 16'h00FF, 3'b000, "R3", 16'h0);
      run_op(mk9(4'hA, 3'd3, 9'h1F8), 16'h30FD, 16'h0, 3'b000, "R4", 16'h0);
      run_op(mk9(4'hB, 3'd4, 9'h055), 16'h1234, 16'h0, 3'b000, "R4", 16'h0);
      run_op(mk9(4'hE, 3'd1, 9'h1FD), 16'h30F7, 16'h0, 3'b000, "R5", 16'h0);
      run_op(mk9(4'hE, 3'd1, 9'h100), 16'h0010, 16'h0, 3'b000, "R12", 16'h0);
      run_op(mk9(4'h0, 3'b010, 9'h005), 16'h3005, 16'h0, 3'b010, "R6", 16'h0);
      run_op(mk9(4'h0, 3'b100, 9'h1FA), 16'h300A, 16'h0, 3'b001, "R6", 16'h0);
      run_op(mk9(4'h0, 3'b000, 9'h010), 16'h300A, 16'h0, 3'b111, "R6", 16'h0);
      run_op(mk9(4'h0, 3'b111, 9'h1FA), 16'h300A, 16'h0, 3'b100, "R6", 16'h0);
      run_op(16'hC1C0, 16'h3003, 16'h4567, 3'b000, "R7", 16'h0);
      run_op(16'hF025, 16'h3011, 16'h0, 3'b000, "R8", 16'h0);
      run_op(16'hF0FF, 16'h8000, 16'h0, 3'b000, "R8", 16'h0);
      run_op(16'h1262, 16'h2222, 16'h7777, 3'b111, "R9", 16'h0);
      run_op(16'h967F, 16'hABCD, 16'h0, 3'b000, "R9", 16'h0);
      run_op(mk9(4'hA, 3'd5, 9'h010), 16'h5000, 16'h0, 3'b000, "R10", 16'hC080);
      run_op(mk9(4'h2, 3'd5, 9'h010), 16'h5000, 16'h0, 3'b000, "R10", 16'hF031);
      for (int i = 0; i < 4; i++) begin   // R11: inputs move, no start
         @(negedge clk);
         instr = 16'h2000 + 16'(i * 37); pc_inc = 16'(i * 911); base_val = ~pc_inc; cc_nzp = 3'(i);
      end
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         n_bad++;
         $display("FAIL watchdog act=%0d exp<=%0d", cycles, WATCHDOG);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule